// File: doc/BRIEF.md
# CRC Scanner Control Register

This block is the byte-wide control register of a memory-integrity CRC scan engine. It sits on a simple register bus with address, write enable, write data and combinational read data. It holds three control functions: a self-clearing soft-reset strobe, a sticky enable for the non-maskable interrupt, and a scan enable that also restarts a scan.

Whether a write may change each bit depends on three things: the engine's busy flag, the current interrupt-enable state, and whether the interrupt has already fired. The engine supplies a busy level, a CRC-failure pulse and a boot-scan-done indication. In return the block drives a one-cycle start pulse, a one-cycle soft-reset pulse that clears the engine's other control and status state, and a latched NMI request.

Top module: `crc_scan_ctrl`

## Requirements
- R1: After rst_ni is asserted, the register reads 0x00 and start_o, soft_rst_o and nmi_o are all low.
- R2: Bits 6..2 always read 0. A read at any address other than REG_OFS returns 0x00. A write of 1s to bits 6..2 changes nothing.
- R3: An accepted write with bit 0 = 1 sets bit 0 and gives a start_o pulse one cycle wide in the cycle after the write. Writing bit 0 = 1 again, even while busy_i is high, gives another pulse.
- R4: Writing bit 0 = 0 leaves bit 0 unchanged and produces no start_o pulse.
- R5: An accepted write with bit 7 = 1 gives a soft_rst_o pulse one cycle wide in the cycle after the write. From that cycle on, bit 0 reads 0. Bit 7 always reads 0.
- R6: While bit 1 is 0, the soft-reset strobe is accepted whether busy_i is high or low.
- R7: While bit 1 is 1, the soft-reset strobe is ignored when busy_i is high and accepted when busy_i is low.
- R8: Bit 1 (NMI enable) can be set only while busy_i is low. Once set, neither a write of 0 nor the soft-reset strobe clears it; only rst_ni does.
- R9: A crc_fail_i pulse while bit 1 is 1 raises nmi_o in the next cycle, and nmi_o stays high until rst_ni. A crc_fail_i pulse while bit 1 is 0 does not raise nmi_o.
- R10: Once nmi_o is high, every write is ignored: no start_o pulse, no soft_rst_o pulse, and no change in the read value.
- R11: boot_scan_done_i sets bit 0 to 1 without a start_o pulse.
- R12: A write that sets bits 7 and 0 together and whose strobe is accepted performs only the soft reset. Bit 0 reads 0 and no start_o pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| addr_i | input | ADDR_W | Register bus address |
| wr_en_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational on addr_i) |
| busy_i | input | 1 | Engine busy level |
| crc_fail_i | input | 1 | CRC mismatch pulse from the engine |
| boot_scan_done_i | input | 1 | Start-up scan has run |
| start_o | output | 1 | One-cycle scan start pulse |
| soft_rst_o | output | 1 | One-cycle clear for the engine's control and status state |
| nmi_o | output | 1 | Latched NMI request |

## Verification
On every cycle the checker verifies the following:
- start_o and soft_rst_o are single-cycle pulses.
- nmi_o and the NMI enable stay set once set.
- nmi_o rises only after a failure that arrived while the enable was set.
- The enable rises only while the engine is idle.
- No pulse leaves the block once the lock is set.
- The reserved and strobe read bits are zero.

Some properties depend on the order of writes, so only the bench scenarios can show them:
- how the busy flag and the enable state gate the strobe,
- that the strobe takes precedence over scan enable,
- that the enable survives a soft reset,
- that a boot scan sets the enable quietly,
- that rst_ni alone clears the lock.

// File: rtl/crc_scan_ctrl_pkg.sv
package crc_scan_ctrl_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned BIT_SRST  = 7;
  localparam int unsigned BIT_NMIEN = 1;
  localparam int unsigned BIT_EN    = 0;

  // accepted actions of one bus write
  typedef struct packed {
    logic srst;
    logic nmien;
    logic en;
  } ctrl_req_t;
endpackage

// File: rtl/crc_scan_wr_gate.sv
module crc_scan_wr_gate
  import crc_scan_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned REG_OFS = 0
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              nmien_q_i,
  input  logic              lock_i,
  output ctrl_req_t         req_o
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

  logic hit;
  assign hit = wr_en_i && (addr_i == OFS) && !lock_i;

  always_comb begin
    req_o       = '0;
    req_o.srst  = hit && wdata_i[BIT_SRST] && (!nmien_q_i || !busy_i);
    req_o.nmien = hit && wdata_i[BIT_NMIEN] && !busy_i;
    // soft reset takes precedence over a start in the same write
    req_o.en    = hit && wdata_i[BIT_EN] && !req_o.srst;
  end
endmodule

// File: rtl/crc_scan_ctrl_regs.sv
module crc_scan_ctrl_regs
  import crc_scan_ctrl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ctrl_req_t req_i,
  input  logic      boot_done_i,
  output logic      en_q_o,
  output logic      nmien_q_o,
  output logic      start_o,
  output logic      soft_rst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q_o     <= 1'b0;
      nmien_q_o  <= 1'b0;
      start_o    <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      start_o    <= req_i.en;
      soft_rst_o <= req_i.srst;
      if (req_i.nmien) nmien_q_o <= 1'b1;
      if (req_i.srst) begin
        en_q_o <= 1'b0;
      end else if (req_i.en || boot_done_i) begin
        en_q_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/crc_scan_nmi.sv
module crc_scan_nmi (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmien_q_i,
  input  logic crc_fail_i,
  output logic nmi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_o <= 1'b0;
    end else if (nmien_q_i && crc_fail_i) begin
      nmi_o <= 1'b1;
    end
  end
endmodule

// File: rtl/crc_scan_ctrl.sv
module crc_scan_ctrl
  import crc_scan_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned REG_OFS = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              busy_i,
  input  logic              crc_fail_i,
  input  logic              boot_scan_done_i,
  output logic              start_o,
  output logic              soft_rst_o,
  output logic              nmi_o
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

  ctrl_req_t req;
  logic      en_q;
  logic      nmien_q;

  crc_scan_wr_gate #(
    .ADDR_W (ADDR_W),
    .REG_OFS(REG_OFS)
  ) u_gate (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .busy_i   (busy_i),
    .nmien_q_i(nmien_q),
    .lock_i   (nmi_o),
    .req_o    (req)
  );

  crc_scan_ctrl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .boot_done_i(boot_scan_done_i),
    .en_q_o     (en_q),
    .nmien_q_o  (nmien_q),
    .start_o    (start_o),
    .soft_rst_o (soft_rst_o)
  );

  crc_scan_nmi u_nmi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nmien_q_i (nmien_q),
    .crc_fail_i(crc_fail_i),
    .nmi_o     (nmi_o)
  );

  // strobe and reserved bits are never stored
  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS) begin
      rdata_o[BIT_NMIEN] = nmien_q;
      rdata_o[BIT_EN]    = en_q;
    end
  end
endmodule

// File: rtl/crc_scan_ctrl_chk.sv
module crc_scan_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       busy_i,
  input logic       crc_fail_i,
  input logic [7:0] rdata_o,
  input logic       start_o,
  input logic       soft_rst_o,
  input logic       nmi_o,
  input logic       nmien_q
);
  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7:2] == 6'b0);

  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_start_needs_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(wr_en_i));

  p_srst_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  p_nmien_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmien_q |=> nmien_q);

  p_nmien_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmien_q) |-> $past(!busy_i));

  p_nmi_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> nmi_o);

  p_nmi_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) |-> $past(crc_fail_i && nmien_q));

  p_locked_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> (!start_o && !soft_rst_o));
endmodule

bind crc_scan_ctrl crc_scan_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .busy_i    (busy_i),
  .crc_fail_i(crc_fail_i),
  .rdata_o   (rdata_o),
  .start_o   (start_o),
  .soft_rst_o(soft_rst_o),
  .nmi_o     (nmi_o),
  .nmien_q   (nmien_q)
);

// File: tb/crc_scan_ctrl_bench.sv
module crc_scan_ctrl_bench;
  localparam int unsigned ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              busy = 1'b0;
  logic              fail = 1'b0;
  logic              boot = 1'b0;
  logic              start, srst, nmi;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  crc_scan_ctrl #(.ADDR_W(ADDR_W), .REG_OFS(0)) u_crc_scan_ctrl (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .addr_i          (addr),
    .wr_en_i         (wr_en),
    .wdata_i         (wdata),
    .rdata_o         (rdata),
    .busy_i          (busy),
    .crc_fail_i      (fail),
    .boot_scan_done_i(boot),
    .start_o         (start),
    .soft_rst_o      (srst),
    .nmi_o           (nmi)
  );

  typedef struct packed {
    logic       wr;
    logic [3:0] ad;
    logic [7:0] wd;
    logic       bz;
    logic       fl;
    logic       bt;
    logic [7:0] e_rd;
    logic       e_st;
    logic       e_sr;
    logic       e_nmi;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'h0, 8'h01, 1'b0, 1'b0, 1'b0, 8'h01, 1'b1, 1'b0, 1'b0},
    '{1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'h0, 8'h01, 1'b1, 1'b0, 1'b0, 8'h01, 1'b1, 1'b0, 1'b0},
    '{1'b1, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'h0, 8'h7C, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'h0, 8'h80, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    '{1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'h0, 8'h81, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    '{1'b1, 4'h0, 8'h02, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'h0, 8'h03, 1'b0, 1'b0, 1'b0, 8'h03, 1'b1, 1'b0, 1'b0},
    '{1'b1, 4'h0, 8'h80, 1'b1, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 1'b0},
    '{1'b1, 4'h0, 8'h80, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b1, 1'b0},
    '{1'b1, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0},
    '{1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0},
    '{1'b0, 4'h1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{1'b0, 4'h0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03, 1'b0, 1'b0, 1'b1},
    '{1'b1, 4'h0, 8'h80, 1'b0, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 1'b1},
    '{1'b1, 4'h0, 8'h01, 1'b0, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 1'b1}
  };

  localparam string TAG [NV] = '{
    "R1", "R3", "R3", "R3", "R4", "R2", "R6", "R5", "R12", "R8",
    "R8", "R7", "R7", "R8", "R11", "R2", "R9", "R10", "R10"
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 time unit after the next rising edge
  task automatic step(input logic w, input logic [3:0] a, input logic [7:0] d,
                      input logic b, input logic f, input logic bt);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; busy = b; fail = f; boot = bt;
    @(posedge clk);
    #1;
    wr_en = 1'b0; fail = 1'b0; boot = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    check("R1", "rdata in reset", rdata, 8'h00);
    check("R1", "nmi in reset", {7'b0, nmi}, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].wr, TBL[i].ad, TBL[i].wd, TBL[i].bz, TBL[i].fl, TBL[i].bt);
      check(TAG[i], "rdata", rdata, TBL[i].e_rd);
      check(TAG[i], "start", {7'b0, start}, {7'b0, TBL[i].e_st});
      check(TAG[i], "soft_rst", {7'b0, srst}, {7'b0, TBL[i].e_sr});
      check(TAG[i], "nmi", {7'b0, nmi}, {7'b0, TBL[i].e_nmi});
    end
    busy = 1'b0; addr = '0;

    // R8 R9: only system reset clears the lock and NMI enable
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9", "nmi after rst_ni", {7'b0, nmi}, 8'h00);
    check("R8", "nmien after rst_ni", rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: failure while NMI enable is 0 raises nothing
    step(1'b0, 4'h0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R9", "nmi with enable 0", {7'b0, nmi}, 8'h00);
    step(1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R9", "nmi stays low", {7'b0, nmi}, 8'h00);

    // R11: boot scan done after reset, no start pulse
    step(1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R11", "rdata after boot", rdata, 8'h01);
    check("R11", "no start on boot", {7'b0, start}, 8'h00);

    // R3: start pulse lasts exactly one cycle
    step(1'b1, 4'h0, 8'h01, 1'b0, 1'b0, 1'b0);
    check("R3", "start pulse", {7'b0, start}, 8'h01);
    step(1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R3", "start ends", {7'b0, start}, 8'h00);

    // R2: write to another address has no effect
    step(1'b1, 4'h2, 8'h80, 1'b0, 1'b0, 1'b0);
    addr = 4'h0;
    #1;
    check("R2", "other-address write ignored", rdata, 8'h01);
    check("R2", "no soft reset on other address", {7'b0, srst}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule